// File: doc/BRIEF.md
# External Bus Hold Controller

This block decides who owns a shared external address/data bus: the local CPU's bus interface or a second master outside the chip. The outside master asks for the bus by pulling an active-low request line low. The controller answers with an active-low acknowledge, but only at a point where no bus cycle is running and no split or locked sequence is still unfinished. While the bus is handed over, the controller stops driving its address, data-enable and strobe outputs. It also stalls any new external access from the local side until the other master lets go of the bus.

Local accesses can break into several bus beats. The number of beats depends on the bus width (8 or 16 bits), on the access size and on the lowest address bit. A locked read-modify-write runs all of its read beats and then repeats them as write beats, and it cannot be interrupted. The request input is asynchronous and passes through a two-stage synchronizer before the grant logic uses it. The hold function works only while the mode-enable input is high.

Top module: `xbus_hold_ctrl`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `hold_ack_n_o`=1, `bus_oe_o`=1, `data_oe_o`=0, `ext_rd_o`=0, `ext_wr_o`=0. With `cpu_req_i`=0, `cpu_stall_o`=0.
- R2: Take an idle controller with `ctrl_mode_i`=1. If `hold_req_n_i` goes low between clock edges, `hold_ack_n_o` is still 1 after the next two rising edges and becomes 0 after the third.
- R3: While `hold_ack_n_o`=0, the outputs are as follows: `bus_oe_o`=0, `data_oe_o`=0, `ext_rd_o`=0, `ext_wr_o`=0.
- R4: After `hold_req_n_i` returns high, `hold_ack_n_o` is still 0 after two rising edges and returns to 1 after the third. At the same time `bus_oe_o` returns to 1.
- R5: On a 16-bit bus (`bus_8bit_i`=0), the size code sets the beat count: 0 = byte, 1 = halfword, 2 = word.
  - A byte takes 1 beat.
  - A halfword takes 1 beat at an even address and 2 at an odd address.
  - A word takes 2 beats at an even address and 3 at an odd address.
  - Beat 0 uses the given address. Beat k>0 uses the address with bit 0 cleared, plus 2k.
- R6: On an 8-bit bus (`bus_8bit_i`=1), a byte takes 1 beat, a halfword 2 and a word 4. Beat k uses the address plus k.
- R7: A hold request that arrives during a multi-beat access is never acknowledged between beats. It is acknowledged on the edge that ends the final beat.
- R8: A locked access (`cpu_rmw_i`=1) first runs its read beats on `ext_rd_o`. It then runs the same addresses again as write beats on `ext_wr_o`, with `data_oe_o`=1. No acknowledge is given between the read and write halves.
- R9: While `ctrl_mode_i`=0, a low `hold_req_n_i` has no effect: `hold_ack_n_o` stays 1 and local accesses run normally.
- R10: While the bus is held, `cpu_req_i`=1 gives `cpu_stall_o`=1 and no strobes. After the release edge, stall drops in the same cycle, and the access's first beat follows the next edge.
- R11: An access is accepted on a rising edge at which `cpu_stall_o`=0 and `cpu_req_i`=1. Its first beat is on the outputs right after that edge, with one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mode_i | input | 1 | Enables the hold request/acknowledge function |
| hold_req_n_i | input | 1 | Asynchronous active-low bus request from the outside master |
| hold_ack_n_o | output | 1 | Active-low hold acknowledge |
| bus_8bit_i | input | 1 | 1 = 8-bit external bus, 0 = 16-bit |
| cpu_req_i | input | 1 | Local external access request, held until accepted |
| cpu_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr_i | input | AW | Byte address of the access |
| cpu_we_i | input | 1 | 1 = write access (ignored when locked) |
| cpu_rmw_i | input | 1 | Locked read-modify-write sequence |
| cpu_stall_o | output | 1 | Request present but not accepted this cycle |
| ext_addr_o | output | AW | Beat address |
| ext_rd_o | output | 1 | Read strobe for the current beat |
| ext_wr_o | output | 1 | Write strobe for the current beat |
| bus_oe_o | output | 1 | Drive enable for address and strobe pins |
| data_oe_o | output | 1 | Drive enable for data pins (write beats) |

## Verification
The request path goes through two synchronizer flops and the state register. A grant or release is therefore due three rising edges after the bench changes `hold_req_n_i` on a falling edge. The bench samples after the second edge, where the old value is still expected, and again after the third. An access accepted on one edge shows beat 0 right after that edge. Every later beat follows one edge apart, so the bench walks the beats cycle by cycle and compares each against the beat list it derives from the count and address rules. In the interrupted case the request is raised in the cycle after acceptance, and the acknowledge must first appear on the edge after the last beat.

// File: rtl/xbh_pkg.sv
package xbh_pkg;
  localparam int unsigned MAX_SPLIT = 4;
  localparam int unsigned BEAT_W    = $clog2(2 * MAX_SPLIT + 1);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xbh_beat_plan.sv
// Splits one local access into bus beats: per-half count and total count.
module xbh_beat_plan
  import xbh_pkg::*;
(
  input  logic              bus8_i,
  input  logic [1:0]        size_i,
  input  logic              addr_lsb_i,
  input  logic              rmw_i,
  output logic [BEAT_W-1:0] split_o,
  output logic [BEAT_W-1:0] total_o
);
  xfer_size_e sz;
  assign sz = xfer_size_e'(size_i);

  always_comb begin
    split_o = BEAT_W'(1);
    if (bus8_i) begin
      case (sz)
        SZ_BYTE: split_o = BEAT_W'(1);
        SZ_HALF: split_o = BEAT_W'(2);
        default: split_o = BEAT_W'(4);
      endcase
    end else begin
      case (sz)
        SZ_BYTE: split_o = BEAT_W'(1);
        SZ_HALF: split_o = addr_lsb_i ? BEAT_W'(2) : BEAT_W'(1);
        default: split_o = addr_lsb_i ? BEAT_W'(3) : BEAT_W'(2);
      endcase
    end
    total_o = rmw_i ? (split_o << 1) : split_o;
  end
endmodule

// File: rtl/xbh_addr_gen.sv
// Maps a beat index onto a bus address and a read/write direction.
module xbh_addr_gen
  import xbh_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0]     base_i,
  input  logic [BEAT_W-1:0] idx_i,
  input  logic [BEAT_W-1:0] split_i,
  input  logic              bus8_i,
  input  logic              rmw_i,
  input  logic              we_i,
  output logic [AW-1:0]     addr_o,
  output logic              wr_o
);
  logic              second_half;
  logic [BEAT_W-1:0] k;
  logic [AW-1:0]     k_ext;

  always_comb begin
    second_half = rmw_i && (idx_i >= split_i);
    k           = second_half ? (idx_i - split_i) : idx_i;
    k_ext       = AW'(k);
    wr_o        = rmw_i ? second_half : we_i;
    if (bus8_i)
      addr_o = base_i + k_ext;
    else if (k == '0)
      addr_o = base_i;
    else
      addr_o = {base_i[AW-1:1], 1'b0} + (k_ext << 1);
  end
endmodule

// File: rtl/xbh_seq.sv
// Ownership sequencer: idle, running a beat sequence, or bus handed over.
module xbh_seq
  import xbh_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_want_i,
  input  logic              cpu_req_i,
  input  logic [1:0]        size_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic              rmw_i,
  input  logic              bus8_i,
  output logic              held_o,
  output logic              busy_o,
  output logic              last_o,
  output logic              accept_o,
  output logic [BEAT_W-1:0] idx_o,
  output logic [BEAT_W-1:0] split_o,
  output logic [AW-1:0]     base_o,
  output logic              bus8_o,
  output logic              rmw_o,
  output logic              we_o
);
  seq_state_e        st;
  logic [BEAT_W-1:0] idx_q, split_q, total_q;
  logic [AW-1:0]     base_q;
  logic              bus8_q, rmw_q, we_q;
  logic [BEAT_W-1:0] plan_split, plan_total;

  xbh_beat_plan u_plan (
    .bus8_i     (bus8_i),
    .size_i     (size_i),
    .addr_lsb_i (addr_i[0]),
    .rmw_i      (rmw_i),
    .split_o    (plan_split),
    .total_o    (plan_total)
  );

  assign accept_o = (st == ST_IDLE) && !hold_want_i && cpu_req_i;
  assign last_o   = (st == ST_RUN) && (idx_q == total_q - BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx_q   <= '0;
      split_q <= '0;
      total_q <= '0;
      base_q  <= '0;
      bus8_q  <= 1'b0;
      rmw_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (hold_want_i) begin
            st <= ST_HOLD;
          end else if (cpu_req_i) begin
            st      <= ST_RUN;
            idx_q   <= '0;
            split_q <= plan_split;
            total_q <= plan_total;
            base_q  <= addr_i;
            bus8_q  <= bus8_i;
            rmw_q   <= rmw_i;
            we_q    <= we_i;
          end
        end
        ST_RUN: begin
          if (last_o) st <= hold_want_i ? ST_HOLD : ST_IDLE;
          else        idx_q <= idx_q + BEAT_W'(1);
        end
        ST_HOLD: begin
          if (!hold_want_i) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign held_o  = (st == ST_HOLD);
  assign busy_o  = (st == ST_RUN);
  assign idx_o   = idx_q;
  assign split_o = split_q;
  assign base_o  = base_q;
  assign bus8_o  = bus8_q;
  assign rmw_o   = rmw_q;
  assign we_o    = we_q;
endmodule

// File: rtl/xbus_hold_ctrl.sv
module xbus_hold_ctrl
  import xbh_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_mode_i,
  input  logic          hold_req_n_i,
  output logic          hold_ack_n_o,
  input  logic          bus_8bit_i,
  input  logic          cpu_req_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic          cpu_rmw_i,
  output logic          cpu_stall_o,
  output logic [AW-1:0] ext_addr_o,
  output logic          ext_rd_o,
  output logic          ext_wr_o,
  output logic          bus_oe_o,
  output logic          data_oe_o
);
  logic              req_n_sync, hold_want;
  logic              seq_held, seq_busy, seq_last, seq_accept;
  logic [BEAT_W-1:0] seq_idx, seq_split;
  logic [AW-1:0]     seq_base, beat_addr;
  logic              seq_bus8, seq_rmw, seq_we, beat_wr;

  xbh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (hold_req_n_i),
    .q_o (req_n_sync)
  );

  assign hold_want = ctrl_mode_i && !req_n_sync;

  xbh_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .hold_want_i (hold_want),
    .cpu_req_i   (cpu_req_i),
    .size_i      (cpu_size_i),
    .addr_i      (cpu_addr_i),
    .we_i        (cpu_we_i),
    .rmw_i       (cpu_rmw_i),
    .bus8_i      (bus_8bit_i),
    .held_o      (seq_held),
    .busy_o      (seq_busy),
    .last_o      (seq_last),
    .accept_o    (seq_accept),
    .idx_o       (seq_idx),
    .split_o     (seq_split),
    .base_o      (seq_base),
    .bus8_o      (seq_bus8),
    .rmw_o       (seq_rmw),
    .we_o        (seq_we)
  );

  xbh_addr_gen #(.AW(AW)) u_addr (
    .base_i  (seq_base),
    .idx_i   (seq_idx),
    .split_i (seq_split),
    .bus8_i  (seq_bus8),
    .rmw_i   (seq_rmw),
    .we_i    (seq_we),
    .addr_o  (beat_addr),
    .wr_o    (beat_wr)
  );

  assign hold_ack_n_o = !seq_held;
  assign bus_oe_o     = !seq_held;
  assign ext_rd_o     = seq_busy && !beat_wr;
  assign ext_wr_o     = seq_busy && beat_wr;
  assign data_oe_o    = seq_busy && beat_wr;
  assign ext_addr_o   = seq_busy ? beat_addr : '0;
  assign cpu_stall_o  = cpu_req_i && !seq_accept;
endmodule

// File: rtl/xbus_hold_ctrl_chk.sv
module xbus_hold_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ctrl_mode_i,
  input logic hold_req_n_i,
  input logic hold_ack_n_o,
  input logic bus_oe_o,
  input logic data_oe_o,
  input logic ext_rd_o,
  input logic ext_wr_o,
  input logic cpu_req_i,
  input logic cpu_stall_o,
  input logic seq_busy,
  input logic seq_last
);
  // R2 / R9: a grant traces back to a low request two edges earlier, with mode enabled
  a_r2_grant_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_n_o) |-> (!$past(hold_req_n_i, 2) && $past(ctrl_mode_i)));

  // R4: a release traces back to a high request or to mode being cleared
  a_r4_release_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_n_o) |-> ($past(hold_req_n_i, 2) || !$past(ctrl_mode_i)));

  // R3: pins float while held
  a_r3_float_when_held: assert property (@(posedge clk) disable iff (rst)
    !hold_ack_n_o |-> (!bus_oe_o && !data_oe_o && !ext_rd_o && !ext_wr_o));

  // R7: a beat that is not the last is always followed by another beat, never a grant
  a_r7_no_split_grant: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !seq_last) |=> (hold_ack_n_o && seq_busy));

  // R10: local request stalls while the bus is held
  a_r10_stall_in_hold: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack_n_o && cpu_req_i) |-> cpu_stall_o);

  // R8: never read and write in the same beat
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd_o && ext_wr_o));
endmodule

bind xbus_hold_ctrl xbus_hold_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctrl_mode_i  (ctrl_mode_i),
  .hold_req_n_i (hold_req_n_i),
  .hold_ack_n_o (hold_ack_n_o),
  .bus_oe_o     (bus_oe_o),
  .data_oe_o    (data_oe_o),
  .ext_rd_o     (ext_rd_o),
  .ext_wr_o     (ext_wr_o),
  .cpu_req_i    (cpu_req_i),
  .cpu_stall_o  (cpu_stall_o),
  .seq_busy     (seq_busy),
  .seq_last     (seq_last)
);

// File: tb/sim_xbus_hold_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_hold_ctrl;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctrl_mode_i = 1'b1;
  logic          hold_req_n_i = 1'b1;
  logic          hold_ack_n_o;
  logic          bus_8bit_i = 1'b0;
  logic          cpu_req_i = 1'b0;
  logic [1:0]    cpu_size_i = 2'd0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic          cpu_we_i = 1'b0;
  logic          cpu_rmw_i = 1'b0;
  logic          cpu_stall_o;
  logic [AW-1:0] ext_addr_o;
  logic          ext_rd_o, ext_wr_o, bus_oe_o, data_oe_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xbus_hold_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .ctrl_mode_i(ctrl_mode_i), .hold_req_n_i(hold_req_n_i),
    .hold_ack_n_o(hold_ack_n_o), .bus_8bit_i(bus_8bit_i), .cpu_req_i(cpu_req_i),
    .cpu_size_i(cpu_size_i), .cpu_addr_i(cpu_addr_i), .cpu_we_i(cpu_we_i),
    .cpu_rmw_i(cpu_rmw_i), .cpu_stall_o(cpu_stall_o), .ext_addr_o(ext_addr_o),
    .ext_rd_o(ext_rd_o), .ext_wr_o(ext_wr_o), .bus_oe_o(bus_oe_o), .data_oe_o(data_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int split_of(input bit b8, input int sz, input bit a0);
    if (b8) return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (sz == 0) return 1;
    if (sz == 1) return a0 ? 2 : 1;
    return a0 ? 3 : 2;
  endfunction

  function automatic int beat_addr(input bit b8, input int base, input int k);
    if (b8) return base + k;
    if (k == 0) return base;
    return (base & ~1) + 2 * k;
  endfunction

  // Runs one access from an idle, unheld controller and checks every beat (R5, R6, R8, R11)
  task automatic run_access(input bit b8, input int sz, input int addr, input bit we,
                            input bit rmw, input string req);
    int n, total;
    n = split_of(b8, sz, addr[0]);
    total = rmw ? 2 * n : n;
    bus_8bit_i = b8; cpu_size_i = sz[1:0]; cpu_addr_i = addr[AW-1:0];
    cpu_we_i = we; cpu_rmw_i = rmw; cpu_req_i = 1'b1;
    check(cpu_stall_o == 1'b0, "R11 accept", cpu_stall_o, 0);
    tick();
    cpu_req_i = 1'b0;
    for (int i = 0; i < total; i++) begin
      bit exp_wr;
      int k;
      exp_wr = rmw ? (i >= n) : we;
      k = (rmw && i >= n) ? i - n : i;
      check(ext_rd_o == !exp_wr && ext_wr_o == exp_wr && data_oe_o == exp_wr,
            req, {ext_rd_o, ext_wr_o, data_oe_o}, {!exp_wr, exp_wr, exp_wr});
      check(int'(ext_addr_o) == beat_addr(b8, addr, k), req, ext_addr_o, beat_addr(b8, addr, k));
      tick();
    end
    check(!ext_rd_o && !ext_wr_o, {req, " end"}, {ext_rd_o, ext_wr_o}, 0);
  endtask

  task automatic t_reset();
    check(hold_ack_n_o && bus_oe_o && !data_oe_o && !ext_rd_o && !ext_wr_o && !cpu_stall_o,
          "R1 reset", {hold_ack_n_o, bus_oe_o, data_oe_o, ext_rd_o, ext_wr_o, cpu_stall_o},
          6'b110000);
  endtask

  task automatic t_grant_release();
    hold_req_n_i = 1'b0;
    tick(); tick();
    check(hold_ack_n_o == 1'b1, "R2 not yet", hold_ack_n_o, 1);
    tick();
    check(hold_ack_n_o == 1'b0, "R2 grant", hold_ack_n_o, 0);
    check(!bus_oe_o && !data_oe_o && !ext_rd_o && !ext_wr_o, "R3 float",
          {bus_oe_o, data_oe_o, ext_rd_o, ext_wr_o}, 0);
    hold_req_n_i = 1'b1;
    tick(); tick();
    check(hold_ack_n_o == 1'b0, "R4 still held", hold_ack_n_o, 0);
    tick();
    check(hold_ack_n_o == 1'b1 && bus_oe_o == 1'b1, "R4 release", {hold_ack_n_o, bus_oe_o}, 3);
  endtask

  task automatic t_beats16();
    run_access(1'b0, 0, 'h100, 1'b0, 1'b0, "R5 byte");
    run_access(1'b0, 1, 'h100, 1'b1, 1'b0, "R5 half even");
    run_access(1'b0, 1, 'h101, 1'b0, 1'b0, "R5 half odd");
    run_access(1'b0, 2, 'h200, 1'b1, 1'b0, "R5 word even");
    run_access(1'b0, 2, 'h201, 1'b0, 1'b0, "R5 word odd");
  endtask

  task automatic t_beats8();
    run_access(1'b1, 0, 'h010, 1'b1, 1'b0, "R6 byte");
    run_access(1'b1, 1, 'h011, 1'b0, 1'b0, "R6 half");
    run_access(1'b1, 2, 'h021, 1'b1, 1'b0, "R6 word");
  endtask

  task automatic t_rmw();
    run_access(1'b0, 0, 'h033, 1'b0, 1'b1, "R8 locked 16");
    run_access(1'b1, 1, 'h040, 1'b0, 1'b1, "R8 locked 8");
  endtask

  // 8-bit word: four beats; request arrives right after acceptance (R7)
  task automatic t_mid_seq();
    bus_8bit_i = 1'b1; cpu_size_i = 2'd2; cpu_addr_i = 'h300;
    cpu_we_i = 1'b0; cpu_rmw_i = 1'b0; cpu_req_i = 1'b1;
    tick();
    cpu_req_i = 1'b0;
    hold_req_n_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(hold_ack_n_o == 1'b1 && ext_rd_o == 1'b1, "R7 beat unbroken",
            {hold_ack_n_o, ext_rd_o}, 3);
      tick();
    end
    check(hold_ack_n_o == 1'b0 && !ext_rd_o, "R7 grant after last", {hold_ack_n_o, ext_rd_o}, 0);
    hold_req_n_i = 1'b1;
    tick(); tick(); tick();
    check(hold_ack_n_o == 1'b1, "R7 released", hold_ack_n_o, 1);
  endtask

  task automatic t_locked_hold();
    bus_8bit_i = 1'b0; cpu_size_i = 2'd2; cpu_addr_i = 'h051;
    cpu_we_i = 1'b0; cpu_rmw_i = 1'b1; cpu_req_i = 1'b1;
    tick();
    cpu_req_i = 1'b0;
    hold_req_n_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(hold_ack_n_o == 1'b1, "R8 locked no grant", hold_ack_n_o, 1);
      tick();
    end
    check(hold_ack_n_o == 1'b0, "R8 grant after write", hold_ack_n_o, 0);
    hold_req_n_i = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic t_mode_off();
    ctrl_mode_i = 1'b0;
    hold_req_n_i = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    check(hold_ack_n_o == 1'b1 && bus_oe_o == 1'b1, "R9 ignored", {hold_ack_n_o, bus_oe_o}, 3);
    run_access(1'b0, 1, 'h0a0, 1'b1, 1'b0, "R9 access runs");
    check(hold_ack_n_o == 1'b1, "R9 still ignored", hold_ack_n_o, 1);
    hold_req_n_i = 1'b1;
    ctrl_mode_i = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic t_stall();
    hold_req_n_i = 1'b0;
    tick(); tick(); tick();
    bus_8bit_i = 1'b0; cpu_size_i = 2'd0; cpu_addr_i = 'h077;
    cpu_we_i = 1'b0; cpu_rmw_i = 1'b0; cpu_req_i = 1'b1;
    #1;
    check(cpu_stall_o == 1'b1, "R10 stall", cpu_stall_o, 1);
    tick();
    check(cpu_stall_o == 1'b1 && !ext_rd_o, "R10 held off", {cpu_stall_o, ext_rd_o}, 2);
    hold_req_n_i = 1'b1;
    tick(); tick();
    check(cpu_stall_o == 1'b1, "R10 still stalled", cpu_stall_o, 1);
    tick();
    check(cpu_stall_o == 1'b0 && hold_ack_n_o == 1'b1, "R10 unstall", {cpu_stall_o, hold_ack_n_o}, 1);
    tick();
    cpu_req_i = 1'b0;
    check(ext_rd_o == 1'b1 && int'(ext_addr_o) == 'h077, "R10 access starts", ext_addr_o, 'h077);
    tick();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_grant_release();
    t_beats16();
    t_beats8();
    t_rmw();
    t_mid_seq();
    t_locked_hold();
    t_mode_off();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule